// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

A memory-mapped real-time counter driven by a one-second enable pulse. It keeps a 32-bit elapsed-seconds up-counter, along with a down-counter that software keeps equal to the one's complement of the up-counter. Two match registers are compared against the up-counter. A match latches a status bit. Each status bit can raise the interrupt line, drive the power-on switch output, or both.

Software sets the time by first setting the counter-hold control bit. It then writes both counters and clears the hold bit. After handling an alarm, software parks the match register at all ones so that the alarm stops firing again. A general-purpose key register lets software record that it has already initialised the block. The bus is a plain single-cycle 32-bit port. Writes take effect on the clock edge, and reads are combinational from the byte address.

Top module: `sec_match_rtc`

## Requirements
- R1: Word registers sit at byte offsets 0x00 (up-counter), 0x04 (down-counter), 0x08 (match 0), 0x0C (match 1), 0x10 (control), 0x14 (status) and 0x18 (key). Offset 0x1C reads zero. After reset, the up-counter, control, status and key read 0, and the down-counter and both match registers read 0xFFFFFFFF.
- R2: Each tick moves the counters by one step when control bit 6 (hold) and control bit 4 (counter reset) are clear. The up-counter increments and the down-counter decrements, and both wrap modulo 2^32.
- R3: While control bit 6 is set, ticks leave both counters unchanged. Bus writes still load the counters.
- R4: A bus write to a counter in the same cycle as a tick loads the written value, and that counter does not also step.
- R5: Writing control bit 4 as 1 resets the counters to 0 (up) and 0xFFFFFFFF (down) on that same edge. The counters stay at these values, ignoring ticks and counter writes, until bit 4 is written back to 0.
- R6: On a tick edge outside counter reset, status bit 0 (or bit 1) is set if the up-counter value after that edge equals match 0 (or match 1). This includes a held counter: the status bit re-arms on every tick while the values stay equal.
- R7: Status bits 0 to 2 are cleared by writing 1. Writing 0 leaves a bit unchanged. If a set and a clear land in the same cycle, the set wins.
- R8: The interrupt output is high exactly when (status bit 0 and control bit 0) or (status bit 1 and control bit 1) is true.
- R9: The power-on switch output is high when control bit 7 is set, or when (status bit 0 and control bit 2) or (status bit 1 and control bit 3) is true. Status bit 2 is set on the edge after that match-driven condition is true.
- R10: The key register stores and returns all 32 bits. Control reads back bits 7, 6, 4, 3, 2, 1 and 0 as written, and all other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle seconds enable, synchronous to clk |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Alarm interrupt |
| pwr_on | output | 1 | Power-on switch output |

## Verification
Two pairs of events can fall in the same cycle. In the first, a counter write coincides with a tick. In the second, a match that sets a status bit coincides with a write-one clear of that same bit. Directed cases place a counter load on a tick edge, and place a status clear on the tick where the held counter still equals the match register. The random phase aims match values a few seconds ahead of the counter, so these collisions recur. Each outcome is judged against the bench's register model, read back through the bus and the two output pins.

// File: rtl/sec_match_rtc.sv
module sec_match_rtc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [4:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        pwr_on
);
  localparam logic [2:0] A_UP = 3'd0, A_DN = 3'd1, A_M0 = 3'd2, A_M1 = 3'd3,
                         A_CTL = 3'd4, A_ST = 3'd5, A_KEY = 3'd6;
  localparam logic [7:0] CTL_MASK = 8'hDF;

  logic [31:0] up_q, dn_q, m0_q, m1_q, key_q, up_d, dn_d;
  logic [7:0]  ctrl_q;
  logic [2:0]  st_q, st_d;

  wire [2:0] wsel = bus_addr[4:2];
  wire unused_lsb = &{1'b0, bus_addr[1:0]};
  wire wr_up  = bus_we && wsel == A_UP;
  wire wr_dn  = bus_we && wsel == A_DN;
  wire wr_m0  = bus_we && wsel == A_M0;
  wire wr_m1  = bus_we && wsel == A_M1;
  wire wr_ctl = bus_we && wsel == A_CTL;
  wire wr_st  = bus_we && wsel == A_ST;
  wire wr_key = bus_we && wsel == A_KEY;

  wire swr = wr_ctl ? bus_wdata[4] : ctrl_q[4];
  wire run = tick && !ctrl_q[6];

  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (swr) begin
      up_d = '0;
      dn_d = '1;
    end else begin
      if (wr_up) up_d = bus_wdata;
      else if (run) up_d = up_q + 32'd1;
      if (wr_dn) dn_d = bus_wdata;
      else if (run) dn_d = dn_q - 32'd1;
    end
  end

  wire hit0 = tick && !swr && up_d == m0_q;
  wire hit1 = tick && !swr && up_d == m1_q;
  wire sw_match = (st_q[0] & ctrl_q[2]) | (st_q[1] & ctrl_q[3]);
  wire [2:0] clr = wr_st ? bus_wdata[2:0] : 3'b000;
  assign st_d = (st_q & ~clr) | {sw_match, hit1, hit0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= '0;
      dn_q   <= '1;
      m0_q   <= '1;
      m1_q   <= '1;
      key_q  <= '0;
      ctrl_q <= '0;
      st_q   <= '0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
      st_q <= st_d;
      if (wr_m0)  m0_q   <= bus_wdata;
      if (wr_m1)  m1_q   <= bus_wdata;
      if (wr_key) key_q  <= bus_wdata;
      if (wr_ctl) ctrl_q <= bus_wdata[7:0] & CTL_MASK;
    end
  end

  assign irq    = (st_q[0] & ctrl_q[0]) | (st_q[1] & ctrl_q[1]);
  assign pwr_on = ctrl_q[7] | sw_match;

  always_comb begin
    case (wsel)
      A_UP:    bus_rdata = up_q;
      A_DN:    bus_rdata = dn_q;
      A_M0:    bus_rdata = m0_q;
      A_M1:    bus_rdata = m1_q;
      A_CTL:   bus_rdata = {24'd0, ctrl_q};
      A_ST:    bus_rdata = {29'd0, st_q};
      A_KEY:   bus_rdata = key_q;
      default: bus_rdata = '0;
    endcase
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_q[6] && !swr && !wr_up) |=> up_q == $past(up_q) + 32'd1);

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !swr && !wr_up && !wr_dn) |=> ($stable(up_q) && $stable(dn_q)));

  // R5
  cnt_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |-> (up_q == 32'd0 && dn_q == 32'hFFFF_FFFF));

  // R7
  st_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[0] && !(wr_st && bus_wdata[0])) |=> st_q[0]);

  // R7
  st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && bus_wdata[1] && !tick) |=> !st_q[1]);

  // R9
  sw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !ctrl_q[7]) |=> st_q[2]);
endmodule

// File: tb/test_sec_match_rtc.sv
module test_sec_match_rtc;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, pwr_on;
  int total = 0, bad = 0;
  bit done = 0;

  sec_match_rtc i_sec_match_rtc (.clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .pwr_on(pwr_on));

  always #5 clk = ~clk;

  logic [31:0] m_up, m_dn, m_m0, m_m1, m_key;
  logic [7:0] m_ctl;
  logic [2:0] m_st;

  task automatic model_reset();
    m_up = 0; m_dn = '1; m_m0 = '1; m_m1 = '1; m_key = 0; m_ctl = 0; m_st = 0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a[4:2])
      3'd0: return m_up;
      3'd1: return m_dn;
      3'd2: return m_m0;
      3'd3: return m_m1;
      3'd4: return {24'd0, m_ctl};
      3'd5: return {29'd0, m_st};
      3'd6: return m_key;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [4:0] a);
    case (a[4:2])
      3'd0, 3'd1: return "R2";
      3'd5: return "R7";
      3'd4, 3'd6: return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_st[0] & m_ctl[0]) | (m_st[1] & m_ctl[1]);
  endfunction

  function automatic logic exp_swm();
    return (m_st[0] & m_ctl[2]) | (m_st[1] & m_ctl[3]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic t, input logic w, input logic [4:0] a, input logic [31:0] d);
    logic swr, run, h0, h1, sw;
    logic [31:0] nu, nd;
    logic [2:0] c;
    swr = (w && a[4:2] == 3'd4) ? d[4] : m_ctl[4];
    run = t && !m_ctl[6];
    nu = m_up; nd = m_dn;
    if (swr) begin nu = 0; nd = '1; end
    else begin
      if (w && a[4:2] == 3'd0) nu = d; else if (run) nu = m_up + 1;
      if (w && a[4:2] == 3'd1) nd = d; else if (run) nd = m_dn - 1;
    end
    h0 = t && !swr && nu == m_m0;
    h1 = t && !swr && nu == m_m1;
    sw = exp_swm();
    c = (w && a[4:2] == 3'd5) ? d[2:0] : 3'b000;
    m_st = (m_st & ~c) | {sw, h1, h0};
    m_up = nu; m_dn = nd;
    if (w) case (a[4:2])
      3'd2: m_m0 = d;
      3'd3: m_m1 = d;
      3'd4: m_ctl = d[7:0] & 8'hDF;
      3'd6: m_key = d;
      default: ;
    endcase
  endtask

  task automatic step(input logic t, input logic w, input logic [4:0] a,
                      input logic [31:0] d, input string tag = "");
    @(negedge clk);
    tick = t; bus_we = w; bus_addr = a; bus_wdata = d;
    #1;
    chk("R8 irq", {31'd0, irq}, {31'd0, exp_irq()});
    chk("R9 pwr_on", {31'd0, pwr_on}, {31'd0, m_ctl[7] | exp_swm()});
    if (!w) chk(tag == "" ? rd_tag(a) : tag, bus_rdata, exp_rd(a));
    @(posedge clk);
    model_step(t, w, a, d);
  endtask

  task automatic rd(input logic [4:0] a, input string tag = "");
    step(1'b0, 1'b0, a, 0, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic t = 1'b0);
    step(t, 1'b1, a, d);
  endtask

  initial begin
    void'($urandom(32'd5150));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values and map, including unused offset
    for (int i = 0; i < 8; i++) rd(5'(i * 4), "R1");
    // R10: key and control readback
    wr(5'h18, 32'hB5C1_3F27); rd(5'h18, "R10");
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, "R10");
    wr(5'h10, 32'h0);
    // R3: load time under hold, ticks ignored
    wr(5'h10, 32'h40);
    wr(5'h00, 32'h0000_0100, 1'b1); wr(5'h04, ~32'h0000_0100, 1'b1);
    step(1, 0, 5'h00, 0, "R3"); step(1, 0, 5'h04, 0, "R3");
    wr(5'h10, 32'h0);
    // R2: stepping and wrap
    step(1, 0, 5'h00, 0, "R2"); step(1, 0, 5'h04, 0, "R2"); rd(5'h00, "R2");
    wr(5'h00, 32'hFFFF_FFFE); step(1, 0, 5'h00, 0, "R2"); step(1, 0, 5'h00, 0, "R2");
    rd(5'h00, "R2"); rd(5'h04, "R2");
    // R4: counter write beats tick
    wr(5'h00, 32'h0000_1000, 1'b1); rd(5'h00, "R4");
    wr(5'h04, 32'h0000_2000, 1'b1); rd(5'h04, "R4");
    // R5: counter reset dominates writes and ticks
    wr(5'h10, 32'h10, 1'b1); rd(5'h00, "R5"); rd(5'h04, "R5");
    wr(5'h00, 32'h55, 1'b1); step(1, 0, 5'h00, 0, "R5"); rd(5'h04, "R5");
    wr(5'h10, 32'h0);
    // R6, R8, R9: match 0 three ticks ahead with irq and switch enables
    wr(5'h10, 32'h05);
    wr(5'h08, m_up + 3);
    repeat (3) step(1, 0, 5'h14, 0, "R6");
    rd(5'h14, "R6"); rd(5'h14, "R9");
    // R7: held counter at match re-arms; clear and set in same cycle, set wins
    wr(5'h10, 32'h45);
    step(1, 1, 5'h14, 32'h1); rd(5'h14, "R7");
    wr(5'h14, 32'h7); rd(5'h14, "R7");
    wr(5'h14, 32'h0); rd(5'h14, "R7");
    wr(5'h08, 32'hFFFF_FFFF); wr(5'h14, 32'h7); rd(5'h14, "R7");
    // R9: force high, then match 1 drives switch
    wr(5'h10, 32'h80); rd(5'h10, "R9");
    wr(5'h10, 32'h0A); wr(5'h0C, m_up + 2);
    repeat (4) step(1, 0, 5'h14, 0, "R9");
    wr(5'h0C, 32'hFFFF_FFFF); wr(5'h14, 32'h7);
    // random phase
    for (int i = 0; i < 5000; i++) begin
      logic t; int r; logic [4:0] a; logic [31:0] d;
      t = ($urandom % 3) == 0;
      r = $urandom % 16;
      a = 5'(($urandom % 8) * 4);
      if (r < 9) step(t, 0, a, 0);
      else begin
        case (a[4:2])
          3'd2, 3'd3: d = m_up + ($urandom % 5);
          3'd4: d = ($urandom & 32'hEF) | ((($urandom % 10) == 0) ? 32'h10 : 32'h0);
          3'd0, 3'd1: d = (($urandom % 2) == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom;
          default: d = $urandom;
        endcase
        step(t, 1, a, d);
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule